// File: doc/BRIEF.md
# Always-On System Time Counter with Compare Interrupts

This block keeps a free-running system time count that every core in the chip reads as one shared value. It runs on a fast always-on clock `clk` and watches two slower counter clock inputs, a base source and an alternate source. Each input passes through a synchroniser and an edge detector. Only one source is active at a time. Every rising edge of the active source adds a programmable increment to a 64-bit binary count. Each source has its own increment, so software can keep the same nominal rate after it changes source.

The count leaves the block in Gray code only, from a register, so a consumer in another clock domain can sample it safely. Four compare frames each hold a 64-bit threshold and an enable. Each frame drives its own level interrupt while the count is at or above its threshold. Software programs the block through a plain write-only register port. There is no data stream, so the block has no valid/ready handshake.

Register map (4-bit word address): 0 = control (bit 0 enable, bit 1 source request: 0 base, 1 alternate); 1 = base-source increment; 2 = alternate-source increment; 3 = count load; 4..7 = compare threshold of frame 0..3; 8 = frame enable mask in bits [3:0].

Top module: `sys_time_counter`

## Requirements
- R1: After reset the counter is disabled, the base source is active, both increments are 1, `count_gray` is 0 and every `cmp_irq` bit is low.
- R2: While enabled, the count rises by the active source's increment for each rising edge of that source. The new count appears on the third rising edge of `clk` that samples the source high. While disabled, the count holds.
- R3: `count_gray` always equals c ^ (c >> 1), where c is the binary count. With an increment of 1, each step flips exactly one output bit.
- R4: Addresses 1 and 2 hold separate increments for the base and alternate sources. Writing the increment of the inactive source does not change the counting rate.
- R5: A source request written through bit 1 of address 0 is adopted on the cycle after the write while the counter is disabled. While enabled, it is adopted only at the next rising edge of the currently active source, and that step still uses the old source's increment.
- R6: A write to address 3 replaces the count only while the counter is disabled. While enabled, the write is ignored.
- R7: `cmp_irq[k]` is high in exactly those cycles in which frame k's enable bit (bit k at address 8) is set and the count shown on `count_gray` is at least the frame's threshold (address 4+k). It rises in the same cycle the count first reaches the threshold.
- R8: `cmp_irq[k]` falls in the cycle after a write that clears bit k of the enable mask or that moves the threshold above the current count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_clk_base | input | 1 | Base counter clock source, asynchronous to clk |
| cnt_clk_alt | input | 1 | Alternate counter clock source, asynchronous to clk |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register word address |
| wr_data | input | 64 | Register write data |
| count_gray | output | 64 | Gray-coded system count |
| cmp_irq | output | 4 | One level interrupt per compare frame |

## Verification
The assertions assume that each counter clock input stays high and stays low for at least three `clk` cycles, so that every source edge produces exactly one step. They also assume that the 64-bit count never wraps, which the sticky-interrupt property relies on. The bench toggles the two sources every five and seven cycles, and it starts from small counts and small increments, so it stays far from wrap. Source switches, loads and threshold rewrites are issued while the sources keep running. This makes the deferred-switch and ignored-load rules meet real edges.

// File: rtl/stc_pkg.sv
package stc_pkg;
  localparam int ADDR_W = 4;

  typedef enum logic [ADDR_W-1:0] {
    REG_CTRL     = 4'd0,
    REG_INC_BASE = 4'd1,
    REG_INC_ALT  = 4'd2,
    REG_LOAD     = 4'd3,
    REG_THR0     = 4'd4,
    REG_FRM_EN   = 4'd8
  } reg_addr_e;

  localparam int CTRL_EN_BIT  = 0;
  localparam int CTRL_SEL_BIT = 1;
endpackage

// File: rtl/stc_edge_sync.sv
module stc_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], async_in};
      last_q <= sync_q[STAGES-1];
    end
  end

  assign rise = sync_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/stc_cmp_frame.sv
module stc_cmp_frame #(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             thr_wr,
  input  logic             mask_wr,
  input  logic             mask_bit,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [CNT_W-1:0] cnt_nx,
  output logic             irq,
  output logic             frm_en
);
  logic [CNT_W-1:0] thr_q, thr_nx;
  logic             en_q, en_nx;

  always_comb begin
    thr_nx = thr_wr  ? wr_data  : thr_q;
    en_nx  = mask_wr ? mask_bit : en_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_q <= '0;
      en_q  <= 1'b0;
      irq   <= 1'b0;
    end else begin
      thr_q <= thr_nx;
      en_q  <= en_nx;
      irq   <= en_nx && (cnt_nx >= thr_nx);
    end
  end

  assign frm_en = en_q;
endmodule

// File: rtl/sys_time_counter.sv
module sys_time_counter #(
  parameter int CNT_W       = 64,
  parameter int INC_W       = 32,
  parameter int N_FRM       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cnt_clk_base,
  input  logic                      cnt_clk_alt,
  input  logic                      wr_en,
  input  logic [stc_pkg::ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]          wr_data,
  output logic [CNT_W-1:0]          count_gray,
  output logic [N_FRM-1:0]          cmp_irq
);
  import stc_pkg::*;

  localparam int N_SRC = 2;
  localparam int PAD_W = CNT_W - INC_W;

  logic [N_SRC-1:0] src_in, rise;
  logic [INC_W-1:0] inc_q [N_SRC];
  logic [INC_W-1:0] inc_act;
  logic             en_q, sel_req_q, sel_act_q, tick;
  logic [CNT_W-1:0] cnt_q, cnt_nx;
  logic [N_FRM-1:0] frm_en;
  logic             wr_ctrl, wr_load, wr_mask;

  assign src_in = {cnt_clk_alt, cnt_clk_base};

  for (genvar s = 0; s < N_SRC; s++) begin : g_src
    stc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (src_in[s]),
      .rise     (rise[s])
    );
  end

  assign wr_ctrl = wr_en && (wr_addr == REG_CTRL);
  assign wr_load = wr_en && (wr_addr == REG_LOAD);
  assign wr_mask = wr_en && (wr_addr == REG_FRM_EN);
  assign inc_act = inc_q[sel_act_q];
  assign tick    = en_q && rise[sel_act_q];

  always_comb begin
    if (tick)                 cnt_nx = cnt_q + {{PAD_W{1'b0}}, inc_act};
    else if (wr_load && !en_q) cnt_nx = wr_data;
    else                      cnt_nx = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q       <= 1'b0;
      sel_req_q  <= 1'b0;
      sel_act_q  <= 1'b0;
      cnt_q      <= '0;
      count_gray <= '0;
      for (int s = 0; s < N_SRC; s++) inc_q[s] <= INC_W'(1);
    end else begin
      if (wr_ctrl) begin
        en_q      <= wr_data[CTRL_EN_BIT];
        sel_req_q <= wr_data[CTRL_SEL_BIT];
      end
      if (wr_en && wr_addr == REG_INC_BASE) inc_q[0] <= wr_data[INC_W-1:0];
      if (wr_en && wr_addr == REG_INC_ALT)  inc_q[1] <= wr_data[INC_W-1:0];
      if (!en_q || tick) sel_act_q <= sel_req_q;
      cnt_q      <= cnt_nx;
      count_gray <= cnt_nx ^ (cnt_nx >> 1);
    end
  end

  for (genvar k = 0; k < N_FRM; k++) begin : g_frm
    stc_cmp_frame #(.CNT_W(CNT_W)) u_frm (
      .clk      (clk),
      .rst_n    (rst_n),
      .thr_wr   (wr_en && (wr_addr == ADDR_W'(REG_THR0) + ADDR_W'(k))),
      .mask_wr  (wr_mask),
      .mask_bit (wr_data[k]),
      .wr_data  (wr_data),
      .cnt_nx   (cnt_nx),
      .irq      (cmp_irq[k]),
      .frm_en   (frm_en[k])
    );
  end
endmodule

// File: rtl/stc_checker.sv
module stc_checker #(
  parameter int CNT_W = 64,
  parameter int INC_W = 32,
  parameter int N_FRM = 4
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       wr_en,
  input logic [stc_pkg::ADDR_W-1:0] wr_addr,
  input logic [CNT_W-1:0]           count_gray,
  input logic [N_FRM-1:0]           cmp_irq,
  input logic [N_FRM-1:0]           frm_en,
  input logic                       en_q,
  input logic                       tick,
  input logic                       sel_act,
  input logic [INC_W-1:0]           inc_act
);
  import stc_pkg::*;

  logic [CNT_W-1:0] bin;
  logic [CNT_W-1:0] inc_ext;

  always_comb begin
    bin[CNT_W-1] = count_gray[CNT_W-1];
    for (int i = CNT_W-2; i >= 0; i--) bin[i] = bin[i+1] ^ count_gray[i];
  end
  assign inc_ext = {{(CNT_W-INC_W){1'b0}}, inc_act};

  AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !(wr_en && wr_addr == REG_LOAD)) |=> $stable(count_gray)); // R2
  AST_STEP_BY_INC: assert property (@(posedge clk) disable iff (!rst_n)
    en_q |=> (bin == $past(bin) || bin == $past(bin) + $past(inc_ext))); // R2
  AST_GRAY_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && inc_act == INC_W'(1)) |=> ($countones(count_gray ^ $past(count_gray)) <= 1)); // R3
  AST_SEL_DEFERRED: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && !tick) |=> $stable(sel_act)); // R5
  AST_NO_LOAD_WHILE_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && !tick) |=> $stable(count_gray)); // R6

  for (genvar k = 0; k < N_FRM; k++) begin : g_irq
    AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      !frm_en[k] |-> !cmp_irq[k]); // R8
    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_irq[k] && !wr_en) |=> cmp_irq[k]); // R7
  end
endmodule

bind sys_time_counter stc_checker #(
  .CNT_W (CNT_W),
  .INC_W (INC_W),
  .N_FRM (N_FRM)
) u_stc_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_en      (wr_en),
  .wr_addr    (wr_addr),
  .count_gray (count_gray),
  .cmp_irq    (cmp_irq),
  .frm_en     (frm_en),
  .en_q       (en_q),
  .tick       (tick),
  .sel_act    (sel_act_q),
  .inc_act    (inc_act)
);

// File: tb/test_sys_time_counter.sv
module test_sys_time_counter;
  localparam int CW = 64;
  localparam int NF = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          src0 = 1'b0, src1 = 1'b0;
  logic          wr_en = 1'b0;
  logic [3:0]    wr_addr = '0;
  logic [CW-1:0] wr_data = '0;
  logic [CW-1:0] count_gray;
  logic [NF-1:0] cmp_irq;

  int    errors = 0;
  int    checks = 0;
  string phase  = "R1";
  bit    done   = 1'b0;

  always #4 clk = ~clk;

  sys_time_counter i_sys_time_counter (
    .clk(clk), .rst_n(rst_n), .cnt_clk_base(src0), .cnt_clk_alt(src1),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .count_gray(count_gray), .cmp_irq(cmp_irq)
  );

  // counter clock sources: half periods of 5 and 7 clk cycles
  int c0 = 0, c1 = 0;
  always @(negedge clk) begin
    c0 = c0 + 1; c1 = c1 + 1;
    if (c0 == 5) begin c0 = 0; src0 <= ~src0; end
    if (c1 == 7) begin c1 = 0; src1 <= ~src1; end
  end

  function automatic logic [CW-1:0] ungray(input logic [CW-1:0] g);
    logic [CW-1:0] b;
    b[CW-1] = g[CW-1];
    for (int i = CW-2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  task automatic check(input string req, input string what,
                       input logic [CW-1:0] act, input logic [CW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // behavioural reference model, advanced on every rising edge
  bit          h0 [4], h1 [4];
  bit          m_en, m_req, m_sel;
  logic [CW-1:0] m_cnt, m_prev;
  logic [31:0] m_inc [2];
  logic [CW-1:0] m_thr [NF];
  logic [NF-1:0] m_fen, m_irq;
  bit          m_unit_step;

  always @(posedge clk) begin
    if (!rst_n) begin
      h0 = '{default: 0}; h1 = '{default: 0};
      m_en = 0; m_req = 0; m_sel = 0; m_cnt = '0; m_prev = '0;
      m_inc[0] = 1; m_inc[1] = 1; m_fen = '0; m_irq = '0; m_unit_step = 0;
      for (int k = 0; k < NF; k++) m_thr[k] = '0;
    end else begin
      bit r0, r1, stp;
      for (int i = 3; i > 0; i--) begin h0[i] = h0[i-1]; h1[i] = h1[i-1]; end
      h0[0] = src0; h1[0] = src1;
      r0 = h0[2] & ~h0[3];
      r1 = h1[2] & ~h1[3];
      stp = m_en && (m_sel ? r1 : r0);
      m_prev = m_cnt;
      m_unit_step = stp && (m_inc[m_sel] == 1);
      if (stp) m_cnt = m_cnt + {32'd0, m_inc[m_sel]};
      else if (wr_en && wr_addr == 4'd3 && !m_en) m_cnt = wr_data;
      if (!m_en || stp) m_sel = m_req;
      if (wr_en) begin
        case (wr_addr)
          4'd0: begin m_en = wr_data[0]; m_req = wr_data[1]; end
          4'd1: m_inc[0] = wr_data[31:0];
          4'd2: m_inc[1] = wr_data[31:0];
          4'd8: m_fen = wr_data[NF-1:0];
          default: if (wr_addr >= 4 && wr_addr < 4 + NF) m_thr[wr_addr-4] = wr_data;
        endcase
      end
      for (int k = 0; k < NF; k++) m_irq[k] = m_fen[k] && (m_cnt >= m_thr[k]);
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(phase, "count", ungray(count_gray), m_cnt);
      check("R3", "gray code", count_gray, m_cnt ^ (m_cnt >> 1));
      check("R7", "irq vector", {60'd0, cmp_irq}, {60'd0, m_irq});
      if (m_unit_step)
        check("R3", "bits flipped", 64'($countones(count_gray ^ (m_prev ^ (m_prev >> 1)))), 64'd1);
    end
  end

  task automatic wr(input logic [3:0] a, input logic [CW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    logic [CW-1:0] snap;
    idle(4);
    check("R1", "reset count", count_gray, 64'd0);
    check("R1", "reset irq", {60'd0, cmp_irq}, 64'd0);
    rst_n = 1'b1;
    phase = "R2";
    idle(40);
    check("R2", "disabled hold", ungray(count_gray), 64'd0);
    phase = "R6";
    wr(4'd3, 64'd100);
    check("R6", "load while off", ungray(count_gray), 64'd100);
    phase = "R2";
    wr(4'd0, 64'h1);
    idle(120);
    check("R2", "advanced", 64'(ungray(count_gray) > 64'd100), 64'd1);
    phase = "R7";
    snap = ungray(count_gray);
    wr(4'd4, snap + 64'd6);
    wr(4'd5, snap + 64'd20);
    wr(4'd6, snap + 64'd3);
    wr(4'd8, 64'h7);
    for (int i = 0; i < 300 && !cmp_irq[0]; i++) @(negedge clk);
    check("R7", "frame0 reached", 64'(ungray(count_gray) >= snap + 64'd6), 64'd1);
    idle(150);
    phase = "R6";
    wr(4'd3, 64'd5);
    idle(3);
    check("R6", "load ignored while on", 64'(ungray(count_gray) > 64'd100), 64'd1);
    phase = "R5";
    wr(4'd2, 64'd3);
    wr(4'd0, 64'h3);
    idle(160);
    phase = "R4";
    wr(4'd1, 64'd7);
    idle(60);
    wr(4'd0, 64'h1);
    idle(120);
    phase = "R8";
    wr(4'd8, 64'h6);
    check("R8", "mask cleared", {63'd0, cmp_irq[0]}, 64'd0);
    wr(4'd6, 64'hFFFF_FFFF_0000_0000);
    check("R8", "threshold raised", {63'd0, cmp_irq[2]}, 64'd0);
    phase = "R7";
    wr(4'd7, ungray(count_gray) + 64'd30);
    wr(4'd8, 64'hA);
    idle(200);
    phase = "R2";
    wr(4'd0, 64'h0);
    snap = ungray(count_gray);
    idle(60);
    check("R2", "hold after disable", ungray(count_gray), snap);
    phase = "R5";
    wr(4'd0, 64'h2);
    idle(4);
    wr(4'd0, 64'h3);
    idle(100);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule